// File: doc/BRIEF.md
# Software-Refilled Data TLB

This block is the data-side translation buffer of a processor that refills its translations in software. Pages are 8 KB. The buffer is organised as 16 sets of 4 ways. Each entry pairs a high word, which holds the virtual page number and a process ID, with a low word, which holds the physical frame number and the permission flags.

On each lookup request the block takes a virtual address, a write flag, the current process ID and two check enables. One cycle later it returns either a hit with a frame number or a fault vector. A fault also records the details of the failing access in a cause register. A miss or an invalid entry loads a refill-select register that points at the slot where the refill handler should write.

The handler refills through three write-only registers: select, hi and lo. A write to hi goes into the cause register. A write to lo commits the lo data into the selected slot, and the commit takes its hi word from the cause register. Two copies of the entry storage exist, and the support-register bank picks which copy a write goes to. Lookups read the copy written under bank 2.

Top module: `dtlb_sw_refill`

## Requirements
- R1: A lookup splits the address into VPN = vaddr[31:13] and set = vaddr[16:13]. It compares the 4 ways of that set with hi[31:13] and uses the lowest-numbered way that matches. The response appears on the cycle after `lk_valid_i`. On a hit, `rsp_hit_o`=1, `rsp_vec_o`=0 and `rsp_pfn_o` = lo[31:13]. The page offset vaddr[12:0] has no effect.
- R2: Entry fields are: hi[7:0] process ID, lo[4] global, lo[3] valid, lo[2] kernel, lo[1] writable, lo[0] executable.
- R3: When no way matches, the vector is 0x8. The select register is then loaded with the set index in bits 3:0 and way 0 in bits 5:4.
- R4: A matching entry with lo[3]=0 while `chk_valid_i`=1 gives vector 0x9 and loads select as in R3. With `chk_valid_i`=0 the valid bit is not checked.
- R5: A matching entry with lo[4]=0, hi[7:0]≠0xFF and hi[7:0]≠`pid_i` gives vector 0xA. A global entry or an entry with process ID 0xFF passes this check.
- R6: A write to a matching entry with lo[1]=0 while `chk_write_i`=1 gives vector 0xB. Reads pass this check. With `chk_write_i`=0 the writable bit is not checked.
- R7: When several faults apply, the priority is miss, then invalid, then process ID, then write protection.
- R8: On a fault, cause becomes {VPN in 31:13, previous bits 12:10, access code in 9:8 (01 read, 10 write), `pid_i` in 7:0}. A hit leaves cause unchanged.
- R9: Register writes use `reg_addr_i` 0 for select (bits 5:0), 1 for hi (copied into cause) and 2 for lo. A lo write commits {hi = cause, lo = data} into set select[3:0], way select[5:4]. A register write wins over a lookup update of the same register in the same cycle.
- R10: Hi and lo writes take effect only when `bank_i` is 1 or 2. Bank 1 writes the copy that lookups do not read, and bank 2 writes the copy they do read. Select writes are not gated.
- R11: After reset every entry is zero (invalid, VPN 0), and select, cause and `rsp_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_vaddr_i | input | 32 | Virtual address of the lookup |
| lk_write_i | input | 1 | Lookup is a write |
| pid_i | input | 8 | Current process ID |
| chk_valid_i | input | 1 | Enable valid-bit checking |
| chk_write_i | input | 1 | Enable write-protect checking |
| bank_i | input | 2 | Selected support-register bank |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 select, 1 hi, 2 lo |
| reg_wdata_i | input | 32 | Register write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after request |
| rsp_hit_o | output | 1 | Translation hit |
| rsp_pfn_o | output | 19 | Physical frame number on hit, else 0 |
| rsp_vec_o | output | 4 | Fault vector (0 on hit) |
| cause_o | output | 32 | Cause register |
| sel_o | output | 6 | Refill-select register |

## Verification
The bench uses the default parameters: 16 sets, 4 ways and 2 storage copies. It places several entries in the same set, so a miss has to pass over ways that are occupied, and one row exercises a match in a way other than way 0. The vectors cover every fault class and the overlapping faults that decide the priority order. Both check enables are turned off on rows where they would otherwise fault. Further directed cases cover the reset contents, bank gating of a commit, storage in the copy that lookups do not read, and a select write that collides with a miss in the same cycle.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
  localparam int VA_W      = 32;
  localparam int PAGE_BITS = 13;
  localparam int VPN_W     = VA_W - PAGE_BITS;
  localparam int PID_W     = 8;

  localparam int LO_G = 4;
  localparam int LO_V = 3;
  localparam int LO_K = 2;
  localparam int LO_W = 1;
  localparam int LO_X = 0;

  localparam logic [1:0] ACC_READ  = 2'b01;
  localparam logic [1:0] ACC_WRITE = 2'b10;

  localparam logic [3:0] VEC_NONE    = 4'h0;
  localparam logic [3:0] VEC_REFILL  = 4'h8;
  localparam logic [3:0] VEC_INVALID = 4'h9;
  localparam logic [3:0] VEC_ACCESS  = 4'hA;
  localparam logic [3:0] VEC_WPROT   = 4'hB;

  localparam logic [1:0] RA_SEL = 2'd0;
  localparam logic [1:0] RA_HI  = 2'd1;
  localparam logic [1:0] RA_LO  = 2'd2;

  typedef struct packed {
    logic [VA_W-1:0] hi;
    logic [VA_W-1:0] lo;
  } entry_t;
endpackage

// File: rtl/dtlb_store.sv
module dtlb_store
  import dtlb_pkg::*;
#(
  parameter int SETS    = 16,
  parameter int WAYS    = 4,
  parameter int COPIES  = 2,
  parameter int LK_COPY = 1,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int CP_W   = (COPIES > 1) ? $clog2(COPIES) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [CP_W-1:0]     wr_copy_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [WAY_W-1:0]    wr_way_i,
  input  entry_t              wr_entry_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output entry_t [WAYS-1:0]   rd_row_o
);
  entry_t mem_q [COPIES][SETS][WAYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < COPIES; c++)
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++)
            mem_q[c][s][w] <= '0;
    end else if (wr_en_i) begin
      for (int c = 0; c < COPIES; c++)
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++)
            if (wr_copy_i == CP_W'(c) && wr_idx_i == IDX_W'(s) && wr_way_i == WAY_W'(w))
              mem_q[c][s][w] <= wr_entry_i;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_row_o[w] = mem_q[LK_COPY][rd_idx_i][w];
  end
endmodule

// File: rtl/dtlb_match.sv
module dtlb_match
  import dtlb_pkg::*;
#(
  parameter int WAYS = 4
) (
  input  entry_t [WAYS-1:0]  row_i,
  input  logic [VPN_W-1:0]   vpn_i,
  input  logic               write_i,
  input  logic [PID_W-1:0]   pid_i,
  input  logic               chk_valid_i,
  input  logic               chk_write_i,
  output logic               hit_o,
  output logic [VPN_W-1:0]   pfn_o,
  output logic [3:0]         vec_o,
  output logic               upd_sel_o
);
  logic [WAYS-1:0] way_eq;
  logic            found;
  entry_t          ent;
  logic [PID_W-1:0] ent_pid;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_eq[w] = (row_i[w].hi[VA_W-1:PAGE_BITS] == vpn_i);
  end

  // lowest matching way wins
  always_comb begin
    found = 1'b0;
    ent   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_eq[w] && !found) begin
        found = 1'b1;
        ent   = row_i[w];
      end
    end
  end

  assign ent_pid = ent.hi[PID_W-1:0];

  always_comb begin
    hit_o     = 1'b0;
    upd_sel_o = 1'b0;
    vec_o     = VEC_NONE;
    if (!found) begin
      vec_o     = VEC_REFILL;
      upd_sel_o = 1'b1;
    end else if (chk_valid_i && !ent.lo[LO_V]) begin
      vec_o     = VEC_INVALID;
      upd_sel_o = 1'b1;
    end else if (!ent.lo[LO_G] && ent_pid != '1 && ent_pid != pid_i) begin
      vec_o = VEC_ACCESS;
    end else if (write_i && chk_write_i && !ent.lo[LO_W]) begin
      vec_o = VEC_WPROT;
    end else begin
      hit_o = 1'b1;
    end
  end

  assign pfn_o = hit_o ? ent.lo[VA_W-1:PAGE_BITS] : '0;
endmodule

// File: rtl/dtlb_ctrl.sv
module dtlb_ctrl
  import dtlb_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int COPIES = 2,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int SEL_W = IDX_W + WAY_W,
  localparam int CP_W  = (COPIES > 1) ? $clog2(COPIES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lk_valid_i,
  input  logic [VPN_W-1:0]   lk_vpn_i,
  input  logic [IDX_W-1:0]   lk_idx_i,
  input  logic               lk_write_i,
  input  logic [PID_W-1:0]   pid_i,
  input  logic               m_hit_i,
  input  logic [VPN_W-1:0]   m_pfn_i,
  input  logic [3:0]         m_vec_i,
  input  logic               m_upd_sel_i,
  input  logic [1:0]         bank_i,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [VA_W-1:0]    reg_wdata_i,
  output logic               rsp_valid_o,
  output logic               rsp_hit_o,
  output logic [VPN_W-1:0]   rsp_pfn_o,
  output logic [3:0]         rsp_vec_o,
  output logic [VA_W-1:0]    cause_o,
  output logic [SEL_W-1:0]   sel_o,
  output logic               commit_o,
  output logic [CP_W-1:0]    commit_copy_o,
  output logic [IDX_W-1:0]   commit_idx_o,
  output logic [WAY_W-1:0]   commit_way_o,
  output entry_t             commit_entry_o
);
  logic bank_ok, wr_sel, wr_hi, fault;
  logic [VA_W-1:0]  cause_q;
  logic [SEL_W-1:0] sel_q;

  assign bank_ok = (bank_i == 2'd1) || (bank_i == 2'd2);
  assign wr_sel  = reg_we_i && reg_addr_i == RA_SEL;
  assign wr_hi   = reg_we_i && reg_addr_i == RA_HI && bank_ok;
  assign fault   = lk_valid_i && !m_hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
    end else if (wr_sel) begin
      sel_q <= reg_wdata_i[SEL_W-1:0];
    end else if (lk_valid_i && m_upd_sel_i) begin
      sel_q <= {{WAY_W{1'b0}}, lk_idx_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
    end else if (wr_hi) begin
      cause_q <= reg_wdata_i;
    end else if (fault) begin
      cause_q <= {lk_vpn_i, cause_q[PAGE_BITS-1:10],
                  lk_write_i ? ACC_WRITE : ACC_READ, pid_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_pfn_o   <= '0;
      rsp_vec_o   <= VEC_NONE;
    end else begin
      rsp_valid_o <= lk_valid_i;
      if (lk_valid_i) begin
        rsp_hit_o <= m_hit_i;
        rsp_pfn_o <= m_pfn_i;
        rsp_vec_o <= m_vec_i;
      end
    end
  end

  assign commit_o       = reg_we_i && reg_addr_i == RA_LO && bank_ok;
  assign commit_copy_o  = CP_W'(bank_i - 2'd1);
  assign commit_idx_o   = sel_q[IDX_W-1:0];
  assign commit_way_o   = sel_q[SEL_W-1:IDX_W];
  assign commit_entry_o = '{hi: cause_q, lo: reg_wdata_i};
  assign cause_o        = cause_q;
  assign sel_o          = sel_q;

  p_rsp_follows_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> rsp_valid_o);
  p_sel_refill_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && m_upd_sel_i && !reg_we_i) |=> sel_q == {{WAY_W{1'b0}}, $past(lk_idx_i)});
  p_cause_pid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault && !reg_we_i) |=> cause_q[PID_W-1:0] == $past(pid_i));
  p_cause_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && m_hit_i && !reg_we_i) |=> $stable(cause_q));
  p_sel_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sel |=> sel_q == $past(reg_wdata_i[SEL_W-1:0]));
endmodule

// File: rtl/dtlb_sw_refill.sv
module dtlb_sw_refill
  import dtlb_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int COPIES = 2
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  lk_valid_i,
  input  logic [31:0]                           lk_vaddr_i,
  input  logic                                  lk_write_i,
  input  logic [7:0]                            pid_i,
  input  logic                                  chk_valid_i,
  input  logic                                  chk_write_i,
  input  logic [1:0]                            bank_i,
  input  logic                                  reg_we_i,
  input  logic [1:0]                            reg_addr_i,
  input  logic [31:0]                           reg_wdata_i,
  output logic                                  rsp_valid_o,
  output logic                                  rsp_hit_o,
  output logic [18:0]                           rsp_pfn_o,
  output logic [3:0]                            rsp_vec_o,
  output logic [31:0]                           cause_o,
  output logic [$clog2(SETS)+$clog2(WAYS)-1:0]  sel_o
);
  localparam int IDX_W   = $clog2(SETS);
  localparam int WAY_W   = $clog2(WAYS);
  localparam int CP_W    = (COPIES > 1) ? $clog2(COPIES) : 1;
  localparam int LK_COPY = COPIES - 1;

  logic [VPN_W-1:0] vpn;
  logic [IDX_W-1:0] idx;
  entry_t [WAYS-1:0] row;
  logic              m_hit, m_upd;
  logic [VPN_W-1:0]  m_pfn;
  logic [3:0]        m_vec;
  logic              commit;
  logic [CP_W-1:0]   commit_copy;
  logic [IDX_W-1:0]  commit_idx;
  logic [WAY_W-1:0]  commit_way;
  entry_t            commit_entry;

  assign vpn = lk_vaddr_i[VA_W-1:PAGE_BITS];
  assign idx = vpn[IDX_W-1:0];

  dtlb_store #(.SETS(SETS), .WAYS(WAYS), .COPIES(COPIES), .LK_COPY(LK_COPY)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i(commit), .wr_copy_i(commit_copy), .wr_idx_i(commit_idx),
    .wr_way_i(commit_way), .wr_entry_i(commit_entry),
    .rd_idx_i(idx), .rd_row_o(row)
  );

  dtlb_match #(.WAYS(WAYS)) u_match (
    .row_i(row), .vpn_i(vpn), .write_i(lk_write_i), .pid_i,
    .chk_valid_i, .chk_write_i,
    .hit_o(m_hit), .pfn_o(m_pfn), .vec_o(m_vec), .upd_sel_o(m_upd)
  );

  dtlb_ctrl #(.SETS(SETS), .WAYS(WAYS), .COPIES(COPIES)) u_ctrl (
    .clk_i, .rst_ni,
    .lk_valid_i, .lk_vpn_i(vpn), .lk_idx_i(idx), .lk_write_i, .pid_i,
    .m_hit_i(m_hit), .m_pfn_i(m_pfn), .m_vec_i(m_vec), .m_upd_sel_i(m_upd),
    .bank_i, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .rsp_valid_o, .rsp_hit_o, .rsp_pfn_o, .rsp_vec_o, .cause_o, .sel_o,
    .commit_o(commit), .commit_copy_o(commit_copy), .commit_idx_o(commit_idx),
    .commit_way_o(commit_way), .commit_entry_o(commit_entry)
  );

  p_hit_no_vec_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_hit_o) |-> (rsp_vec_o == VEC_NONE));
  p_fault_no_pfn_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> (rsp_pfn_o == '0 && rsp_vec_o[3]));
endmodule

// File: tb/dtlb_sw_refill_tb.sv
module dtlb_sw_refill_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0, lk_write = 1'b0, chk_v = 1'b0, chk_w = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  pid = '0;
  logic [1:0]  bank = 2'd2;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        rsp_valid, rsp_hit;
  logic [18:0] rsp_pfn;
  logic [3:0]  rsp_vec;
  logic [31:0] cause;
  logic [5:0]  sel;

  int checks = 0;
  int fails = 0;
  logic [31:0] exp_cause = '0;
  logic [5:0]  exp_sel = '0;

  always #4 clk = ~clk;

  dtlb_sw_refill u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_vaddr_i(lk_vaddr), .lk_write_i(lk_write), .pid_i(pid),
    .chk_valid_i(chk_v), .chk_write_i(chk_w), .bank_i(bank),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_pfn_o(rsp_pfn),
    .rsp_vec_o(rsp_vec), .cause_o(cause), .sel_o(sel)
  );

  typedef struct packed {
    logic [18:0] vpn;
    logic [12:0] off;
    logic        wr;
    logic [7:0]  pid;
    logic        cv;
    logic        cw;
    logic [3:0]  vec;
    logic [18:0] pfn;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VT [NV] = '{
    '{19'h00123, 13'h0000, 1'b0, 8'h05, 1'b1, 1'b1, 4'h0, 19'h04AB0}, // R1 hit way0
    '{19'h00123, 13'h1FFF, 1'b1, 8'h05, 1'b1, 1'b1, 4'h0, 19'h04AB0}, // R1 offset ignored
    '{19'h7F013, 13'h0010, 1'b0, 8'h05, 1'b1, 1'b1, 4'h0, 19'h11111}, // R1 hit way2
    '{19'h7F013, 13'h0000, 1'b1, 8'h05, 1'b1, 1'b1, 4'hB, 19'h00000}, // R6 write protect
    '{19'h7F013, 13'h0000, 1'b1, 8'h05, 1'b1, 1'b0, 4'h0, 19'h11111}, // R6 check off
    '{19'h00223, 13'h0000, 1'b0, 8'h05, 1'b1, 1'b1, 4'h8, 19'h00000}, // R3 miss, set full of others
    '{19'h00A05, 13'h0000, 1'b0, 8'h09, 1'b1, 1'b1, 4'h9, 19'h00000}, // R4 invalid
    '{19'h00A05, 13'h0000, 1'b1, 8'h09, 1'b0, 1'b1, 4'h0, 19'h00ABC}, // R4 check off
    '{19'h00123, 13'h0000, 1'b0, 8'h06, 1'b1, 1'b1, 4'hA, 19'h00000}, // R5 pid mismatch
    '{19'h3C005, 13'h0000, 1'b1, 8'h06, 1'b1, 1'b1, 4'h0, 19'h02222}, // R5 global
    '{19'h00017, 13'h0000, 1'b0, 8'h12, 1'b1, 1'b1, 4'h0, 19'h00777}, // R5 pid 0xFF
    '{19'h00009, 13'h0000, 1'b1, 8'h50, 1'b1, 1'b1, 4'h9, 19'h00000}, // R7 invalid over pid/write
    '{19'h1000A, 13'h0000, 1'b1, 8'h41, 1'b1, 1'b1, 4'hA, 19'h00000}, // R7 pid over write
    '{19'h1000A, 13'h0000, 1'b1, 8'h40, 1'b1, 1'b1, 4'hB, 19'h00000}, // R7 write alone
    '{19'h0000B, 13'h0000, 1'b0, 8'h05, 1'b1, 1'b1, 4'h8, 19'h00000}, // R10 bank1 copy unseen
    '{19'h00A05, 13'h0000, 1'b0, 8'h77, 1'b0, 1'b1, 4'hA, 19'h00000}  // R7 invalid off -> pid
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] bk, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bank = bk; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a == 2'd0) exp_sel = d[5:0];
    if (a == 2'd1 && (bk == 2'd1 || bk == 2'd2)) exp_cause = d;
  endtask

  task automatic fill(input logic [1:0] bk, input logic [18:0] vpn, input logic [1:0] way,
                      input logic [7:0] p, input logic [18:0] pfn, input logic [4:0] fl);
    reg_wr(bk, 2'd0, {26'd0, way, vpn[3:0]});
    reg_wr(bk, 2'd1, {vpn, 5'd0, p});
    reg_wr(bk, 2'd2, {pfn, 8'd0, fl});
  endtask

  task automatic lookup(input logic [18:0] vpn, input logic [12:0] off, input logic wr,
                        input logic [7:0] p, input logic cv, input logic cw);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = {vpn, off}; lk_write = wr; pid = p; chk_v = cv; chk_w = cw;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string req, input logic [18:0] vpn, input logic wr,
                            input logic [7:0] p, input logic [3:0] vec, input logic [18:0] pfn);
    chk({req, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk({req, " hit"}, 64'(rsp_hit), 64'(vec == 4'h0));
    chk({req, " vec"}, 64'(rsp_vec), 64'(vec));
    chk({req, " pfn"}, 64'(rsp_pfn), 64'(pfn));
    if (vec != 4'h0) exp_cause = {vpn, exp_cause[12:10], wr ? 2'b10 : 2'b01, p};
    if (vec == 4'h8 || vec == 4'h9) exp_sel = {2'b00, vpn[3:0]};
    chk({req, "/R8 cause"}, 64'(cause), 64'(exp_cause));
    chk({req, "/R3 sel"}, 64'(sel), 64'(exp_sel));
  endtask

  function automatic string tag_of(input logic [3:0] v);
    case (v)
      4'h8: return "R3";
      4'h9: return "R4";
      4'hA: return "R5";
      4'hB: return "R6";
      default: return "R1";
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R11 sel", 64'(sel), 64'd0);
    chk("R11 cause", 64'(cause), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 idle rsp_valid", 64'(rsp_valid), 64'd0);

    // R11 zeroed entries: VPN 0 matches, invalid
    lookup(19'h0, 13'h0, 1'b0, 8'h00, 1'b0, 1'b1);
    expect_rsp("R11 zero entry unchecked", 19'h0, 1'b0, 8'h00, 4'h0, 19'h0);
    lookup(19'h0, 13'h0, 1'b0, 8'h00, 1'b1, 1'b1);
    expect_rsp("R11 zero entry invalid", 19'h0, 1'b0, 8'h00, 4'h9, 19'h0);

    // R9/R2 refill through registers
    fill(2'd2, 19'h00123, 2'd0, 8'h05, 19'h04AB0, 5'h0A);
    fill(2'd2, 19'h7F013, 2'd2, 8'h05, 19'h11111, 5'h08);
    fill(2'd2, 19'h00A05, 2'd1, 8'h09, 19'h00ABC, 5'h02);
    fill(2'd2, 19'h3C005, 2'd3, 8'h33, 19'h02222, 5'h1A);
    fill(2'd2, 19'h00017, 2'd0, 8'hFF, 19'h00777, 5'h0A);
    fill(2'd2, 19'h00009, 2'd1, 8'h22, 19'h00999, 5'h00);
    fill(2'd2, 19'h1000A, 2'd0, 8'h40, 19'h0AAAA, 5'h08);
    fill(2'd1, 19'h0000B, 2'd0, 8'h05, 19'h0BBBB, 5'h0A); // R10 bank1 copy
    chk("R9 hi write lands in cause", 64'(cause), 64'({19'h0000B, 5'd0, 8'h05}));
    chk("R9 select write", 64'(sel), 64'(6'h0B));

    for (int i = 0; i < NV; i++) begin
      lookup(VT[i].vpn, VT[i].off, VT[i].wr, VT[i].pid, VT[i].cv, VT[i].cw);
      expect_rsp(tag_of(VT[i].vec), VT[i].vpn, VT[i].wr, VT[i].pid, VT[i].vec, VT[i].pfn);
    end

    // R10 hi write under bank 0 leaves cause alone
    reg_wr(2'd0, 2'd1, 32'hDEAD_E0FF);
    chk("R10 gated hi write", 64'(cause), 64'(exp_cause));

    // R10 lo write under bank 0 commits nothing
    reg_wr(2'd2, 2'd0, {26'd0, 2'd0, 4'hC});
    reg_wr(2'd2, 2'd1, {19'h0000C, 5'd0, 8'h05});
    reg_wr(2'd0, 2'd2, {19'h0CCCC, 8'd0, 5'h0A});
    lookup(19'h0000C, 13'h0, 1'b0, 8'h05, 1'b1, 1'b1);
    expect_rsp("R10 gated lo write", 19'h0000C, 1'b0, 8'h05, 4'h8, 19'h0);

    // R9 same-cycle select write wins over miss update
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = {19'h00223, 13'h0}; lk_write = 1'b0; pid = 8'h05;
    chk_v = 1'b1; chk_w = 1'b1;
    bank = 2'd2; reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h0000_0031;
    @(negedge clk);
    lk_valid = 1'b0; reg_we = 1'b0;
    chk("R9 select write priority", 64'(sel), 64'(6'h31));
    chk("R9 miss vec alongside", 64'(rsp_vec), 64'(4'h8));

    // R9 commit into the written slot (set 3 way 3) then hit
    reg_wr(2'd2, 2'd1, {19'h00523, 5'd0, 8'h05});
    reg_wr(2'd2, 2'd0, 32'h0000_0033);
    reg_wr(2'd2, 2'd2, {19'h05555, 8'd0, 5'h0A});
    lookup(19'h00523, 13'h0, 1'b1, 8'h05, 1'b1, 1'b1);
    expect_rsp("R9 commit hit", 19'h00523, 1'b1, 8'h05, 4'h0, 19'h05555);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule